// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register File with Masked Writes

This block is the register file of one eight-pin general-purpose I/O port. Three writable registers control each pin: a GPIO-enable bit that hands the pin to this block, an output-enable bit that turns the pin into a driver, and an output-value bit. A fourth, read-only register returns the pad levels after a two-flop synchronizer. Software reaches all of them over a simple 32-bit register bus with single-cycle write strobes and read data returned one cycle after the read strobe.

Each writable register can be written at two addresses. The plain address replaces all eight bits. The masked alias, at a fixed offset above the plain address, carries a per-pin select in the upper byte of the data and the new pin values in the lower byte. Only selected pins change, so one pin can be flipped without a read-modify-write and without racing another agent that owns a different pin. A pin drives its pad only when both its GPIO-enable and output-enable bits are set.

Top module: `gpio_port_regfile`

## Requirements
- R1: After reset, the GPIO-enable, output-enable and output-value registers read as zero, and `pad_oe` and `pad_out` are all zero.
- R2: A write at a plain address (GPIO-enable 0x00, output-enable 0x10, output-value 0x20) loads data bits [7:0] into that register; bits [31:8] have no effect.
- R3: A write at a masked alias (plain address + 0x80, i.e. 0x80, 0x90, 0xA0) sets pin n of the register to data bit n when data bit 8+n is 1, and leaves every pin whose bit 8+n is 0 unchanged.
- R4: `pad_oe[n]` is 1 exactly when GPIO-enable bit n and output-enable bit n are both 1; `pad_out[n]` equals output-value bit n while `pad_oe[n]` is 1 and is 0 otherwise.
- R5: A read at 0x30 returns the pad levels through two flops: a level applied before clock edge k is returned by a read sampled at edge k+2 or later, while a read sampled at edge k+1 still returns the previous level.
- R6: Writes at 0x30 and at 0xB0 change no register and no output.
- R7: Read data appears in the cycle after the read strobe, in bits [7:0] with bits [31:8] zero; in a cycle that follows no read strobe the read data is zero.
- R8: A read at a masked alias address, or at any address other than 0x00, 0x10, 0x20, 0x30, returns zero; a write at an address outside 0x00, 0x10, 0x20, 0x80, 0x90, 0xA0 changes nothing.
- R9: When a read and a write to the same register are strobed in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad output values, gated |
| pad_oe | output | 8 | Pad output enables |

## Verification
A wrong bit in the GPIO-enable or output-enable register shows on `pad_oe` right after the clock edge that stored it, and a wrong output-value bit shows on `pad_out` in the same cycle whenever that pin is driven; undriven pins show their state only through a read, one cycle after the strobe. A masked write that disturbs an unselected pin is therefore caught either on the pads at once or by the next read of that register. A synchronizer of the wrong depth shows as the new pad level arriving one read early or late, which the bench pins down by reading on consecutive edges right after a pad change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NUM_FIELDS   = 4;
    localparam int NUM_WRITABLE = 3;

    typedef enum logic [1:0] {
        FLD_CFG = 2'd0,
        FLD_OE  = 2'd1,
        FLD_OUT = 2'd2,
        FLD_IN  = 2'd3
    } field_e;

    typedef struct packed {
        logic   hit;
        logic   masked;
        field_e fld;
    } decode_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int FIELD_STRIDE = 16,
    parameter int MASK_OFS     = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    always_comb begin
        dec = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (addr == ADDR_W'(f * FIELD_STRIDE)) begin
                dec.hit    = 1'b1;
                dec.masked = 1'b0;
                dec.fld    = field_e'(2'(f));
            end
            if (f < NUM_WRITABLE && addr == ADDR_W'(f * FIELD_STRIDE + MASK_OFS)) begin
                dec.hit    = 1'b1;
                dec.masked = 1'b1;
                dec.fld    = field_e'(2'(f));
            end
        end
    end

endmodule

// File: rtl/gpio_port_field.sv
module gpio_port_field #(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_plain,
    input  logic              wr_masked,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0]   value_q
);

    typedef struct packed {
        logic [PINS-1:0] value;
    } field_state_t;

    field_state_t    state_d, state_q;
    logic [PINS-1:0] sel_mask;
    logic [PINS-1:0] new_bits;

    assign sel_mask = wdata[PINS +: PINS];
    assign new_bits = wdata[PINS-1:0];

    always_comb begin
        state_d = state_q;
        if (wr_plain) begin
            state_d.value = new_bits;
        end else if (wr_masked) begin
            state_d.value = (state_q.value & ~sel_mask) | (new_bits & sel_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value_q = state_q.value;

    // R1: first edge out of reset sees the cleared value
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (value_q == '0));

    // R2: plain write loads the low data bits
    a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_plain |=> (value_q == $past(new_bits)));

    // R3: unselected pins keep their value across a masked write
    a_r3_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_masked && !wr_plain) |=> (((value_q ^ $past(value_q)) & ~$past(sel_mask)) == '0));

    // R3: selected pins take the supplied value
    a_r3_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_masked && !wr_plain) |=> ((value_q & $past(sel_mask)) == ($past(new_bits) & $past(sel_mask))));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_sync
);

    typedef struct packed {
        logic [PINS-1:0] stage1;
        logic [PINS-1:0] stage2;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.stage1 = pad_in;
        state_d.stage2 = state_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pad_sync = state_q.stage2;

    // R5: synchronized value is the pad level from two edges earlier
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pad_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_port_regfile.sv
module gpio_port_regfile
    import gpio_port_pkg::*;
#(
    parameter int PINS         = 8,
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int FIELD_STRIDE = 16,
    parameter int MASK_OFS     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    localparam int WR_BITS = 2 * PINS;
    localparam logic [ADDR_W-1:0] IN_ADDR      = ADDR_W'(int'(FLD_IN) * FIELD_STRIDE);
    localparam logic [ADDR_W-1:0] IN_MASK_ADDR = ADDR_W'(int'(FLD_IN) * FIELD_STRIDE + MASK_OFS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    decode_t         dec;
    logic [PINS-1:0] fld_q [NUM_WRITABLE];
    logic [PINS-1:0] pad_sync;
    logic            unused_wdata_hi;
    rd_state_t       state_d, state_q;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WR_BITS];

    gpio_port_decode #(
        .ADDR_W       (ADDR_W),
        .FIELD_STRIDE (FIELD_STRIDE),
        .MASK_OFS     (MASK_OFS)
    ) u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar f = 0; f < NUM_WRITABLE; f++) begin : g_field
        logic sel;
        assign sel = bus_wr && dec.hit && (dec.fld == field_e'(2'(f)));

        gpio_port_field #(
            .PINS (PINS)
        ) u_field (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_plain  (sel && !dec.masked),
            .wr_masked (sel && dec.masked),
            .wdata     (bus_wdata[WR_BITS-1:0]),
            .value_q   (fld_q[f])
        );
    end

    gpio_port_sync #(
        .PINS (PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        if (bus_rd && dec.hit && !dec.masked) begin
            unique case (dec.fld)
                FLD_CFG: state_d.rdata[PINS-1:0] = fld_q[FLD_CFG];
                FLD_OE:  state_d.rdata[PINS-1:0] = fld_q[FLD_OE];
                FLD_OUT: state_d.rdata[PINS-1:0] = fld_q[FLD_OUT];
                FLD_IN:  state_d.rdata[PINS-1:0] = pad_sync;
                default: state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign pad_oe    = fld_q[FLD_CFG] & fld_q[FLD_OE];
    assign pad_out   = fld_q[FLD_OUT] & pad_oe;

    // R6: writes at the input register or its alias leave all registers alone
    a_r6_input_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == IN_ADDR || bus_addr == IN_MASK_ADDR)) |=>
            ($stable(fld_q[0]) && $stable(fld_q[1]) && $stable(fld_q[2])));

    // R7: no read strobe, no read data
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R7: upper read bits stay zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PINS] == '0);

    // R8: alias reads return zero
    a_r8_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.masked) |=> (bus_rdata == '0));

    // R9: read and write together return the old value
    a_r9_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && dec.hit && !dec.masked && dec.fld == FLD_CFG) |=>
            (bus_rdata[PINS-1:0] == $past(fld_q[0])));

endmodule

// File: tb/gpio_port_regfile_tb.sv
module gpio_port_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    chk_en   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // behavioural reference state
    int m_cfg, m_oe, m_out, m_s1, m_s2, m_rd, m_next_rd;

    gpio_port_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #5 clk = ~clk;

    function automatic int apply_mask(int cur, logic [31:0] wd);
        int r = cur;
        for (int n = 0; n < 8; n++) begin
            if (wd[8+n]) r = wd[n] ? (r | (1 << n)) : (r & ~(1 << n));
        end
        return r;
    endfunction

    function automatic int model_read(logic [11:0] a);
        case (a)
            12'h000: return m_cfg;
            12'h010: return m_oe;
            12'h020: return m_out;
            12'h030: return m_s2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_oe = 0; m_out = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
        end else begin
            m_next_rd = bus_rd ? model_read(bus_addr) : 0;
            if (bus_wr) begin
                case (bus_addr)
                    12'h000: m_cfg = int'(bus_wdata[7:0]);
                    12'h010: m_oe  = int'(bus_wdata[7:0]);
                    12'h020: m_out = int'(bus_wdata[7:0]);
                    12'h080: m_cfg = apply_mask(m_cfg, bus_wdata);
                    12'h090: m_oe  = apply_mask(m_oe, bus_wdata);
                    12'h0A0: m_out = apply_mask(m_out, bus_wdata);
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = int'(pad_in);
            m_rd = m_next_rd;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(cur_req, bus_rdata, 32'(m_rd));
            check("R4 pad_oe", {24'h0, pad_oe}, 32'(m_cfg & m_oe));
            check("R4 pad_out", {24'h0, pad_out}, 32'(m_cfg & m_oe & m_out));
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [11:0] addrs [10];
        addrs = '{12'h000, 12'h010, 12'h020, 12'h030, 12'h080,
                  12'h090, 12'h0A0, 12'h0B0, 12'h004, 12'h044};

        repeat (3) @(negedge clk);
        check("R1 pad_oe in reset", {24'h0, pad_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;

        // R1: reset values
        cur_req = "R1";
        rd(12'h000, d); check("R1 cfg", d, 32'h0);
        rd(12'h010, d); check("R1 oe", d, 32'h0);
        rd(12'h020, d); check("R1 out", d, 32'h0);

        // R2: plain write, upper bits ignored
        cur_req = "R2";
        wr(12'h000, 32'hFFFF_FFA5);
        rd(12'h000, d); check("R2 cfg plain", d, 32'h0000_00A5);

        // R3: masked write pins 0 and 1
        cur_req = "R3";
        wr(12'h080, 32'h0000_0302);
        rd(12'h000, d); check("R3 cfg masked", d, 32'h0000_00A6);
        wr(12'h080, 32'h0000_00FF);
        rd(12'h000, d); check("R3 empty mask", d, 32'h0000_00A6);

        // R4: pad gating
        cur_req = "R4";
        wr(12'h010, 32'h0000_000F);
        wr(12'h020, 32'h0000_00FF);
        check("R4 pad_oe", {24'h0, pad_oe}, 32'h06);
        check("R4 pad_out", {24'h0, pad_out}, 32'h06);
        wr(12'h090, 32'h0000_0200);
        check("R4 oe cleared pin1", {24'h0, pad_oe}, 32'h04);
        check("R4 out follows oe", {24'h0, pad_out}, 32'h04);
        wr(12'h0A0, 32'h0000_FF00);
        check("R4 out zero", {24'h0, pad_out}, 32'h00);
        check("R4 oe kept", {24'h0, pad_oe}, 32'h04);

        // R5: two-stage input timing
        cur_req = "R5";
        pad_in = 8'h5A; bus_rd = 1'b1; bus_addr = 12'h030;
        @(negedge clk); check("R5 read at k", bus_rdata, 32'h0);
        @(negedge clk); check("R5 read at k+1", bus_rdata, 32'h0);
        @(negedge clk); check("R5 read at k+2", bus_rdata, 32'h5A);
        bus_rd = 1'b0;

        // R6: writes to input register ignored
        cur_req = "R6";
        wr(12'h030, 32'hFFFF_FFFF);
        wr(12'h0B0, 32'h0000_FFFF);
        rd(12'h030, d); check("R6 input kept", d, 32'h5A);
        rd(12'h000, d); check("R6 cfg kept", d, 32'hA6);
        rd(12'h010, d); check("R6 oe kept", d, 32'h0D);
        rd(12'h020, d); check("R6 out kept", d, 32'h00);

        // R8: alias and unmapped reads, unmapped write
        cur_req = "R8";
        rd(12'h080, d); check("R8 alias read", d, 32'h0);
        rd(12'h004, d); check("R8 unmapped read", d, 32'h0);
        wr(12'h044, 32'h0000_FFFF);
        rd(12'h000, d); check("R8 cfg after stray write", d, 32'hA6);

        // R7: idle cycle read data is zero
        cur_req = "R7";
        @(negedge clk);
        check("R7 idle zero", bus_rdata, 32'h0);

        // R9: read and write same cycle
        cur_req = "R9";
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h33;
        @(negedge clk);
        check("R9 old value", bus_rdata, 32'hA6);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rd(12'h000, d); check("R9 new value", d, 32'h33);

        // R3: mixed traffic against the model
        cur_req = "R3";
        for (int i = 0; i < 600; i++) begin
            bus_wr    = ($urandom % 2) == 0;
            bus_rd    = ($urandom % 2) == 0;
            bus_addr  = addrs[$urandom % 10];
            bus_wdata = $urandom;
            if (($urandom % 4) == 0) pad_in = 8'($urandom);
            @(negedge clk);
        end
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);

        finish_run();
    end

endmodule